// File: doc/BRIEF.md
# External Data Access Router

This block sits beside an 8051-class core and decides, for every external data access, which of three targets serves it: a 4 KB internal auxiliary RAM, an internal nonvolatile data region, or the external bus. The choice depends on the address and also on how the access was addressed. It can come from a 16-bit pointer, or from an 8-bit register-indirect access whose upper address bits come from a page register held inside the block.

Routing is combinational. For the access currently presented, the block drives one target select, the full 16-bit effective address, a flag that says whether the upper address byte may be driven on the external pins, and the minimum number of wait cycles the core must allow. The auxiliary RAM array is also inside the block. A write to it lands at the clock edge of the access, and read data appears registered one edge after the access. The nonvolatile array and the external bus timing are outside the block.

Top module: `movx_router`

## Requirements
- R1: A valid 16-bit pointer access (acc_short=0) with the IAP control bit low, EXRAM low and an address below 1000H selects the auxiliary RAM, with eff_addr equal to acc_addr and min_wait equal to 2.
- R2: A valid 8-bit access (acc_short=1) with EXRAM low and page_q below 10H selects the auxiliary RAM at eff_addr = {page_q, acc_addr[7:0]}. acc_addr[15:8] is ignored, and both register pointers share this one page value.
- R3: A valid 8-bit access with EXRAM low and page_q from 10H to FFH selects the external bus with eff_addr = {8'h00, acc_addr[7:0]} and addr_hi_en=0, so the page value never reaches the upper address pins.
- R4: With IAP high, a 16-bit access never reaches the auxiliary RAM or the nonvolatile region; it selects the external bus.
- R5: With IAP low and DMEN high, a 16-bit access in 1000H..2FFFH selects the nonvolatile region with min_wait equal to 4. With DMEN low, the same range selects the external bus.
- R6: With EXRAM high, every valid access selects the external bus. For a 16-bit access eff_addr = acc_addr and addr_hi_en=1. For an 8-bit access eff_addr = {8'h00, acc_addr[7:0]} and addr_hi_en=0.
- R7: A 16-bit access to 3000H or above, with EXRAM low, selects the external bus with eff_addr = acc_addr, addr_hi_en=1 and min_wait equal to 1. Every external selection reports min_wait 1.
- R8: While acc_valid is high, exactly one of sel_aux, sel_nv and sel_ext is high. While acc_valid is low, all three are low and min_wait is 0.
- R9: page_q is 00H after a synchronous reset. A cycle with page_we high loads page_wdata into page_q at that clock edge.
- R10: A write access that selects the auxiliary RAM stores acc_wdata at eff_addr[11:0]. A later read access that selects the same location returns that byte on rd_data after the clock edge of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_short | input | 1 | 1 = 8-bit register-indirect access, 0 = 16-bit pointer access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Access address (only bits 7:0 used when acc_short=1) |
| acc_wdata | input | 8 | Write data |
| page_we | input | 1 | Load the page register |
| page_wdata | input | 8 | New page value |
| exram | input | 1 | Force every access to the external bus |
| iap | input | 1 | When high, 16-bit accesses bypass the internal regions |
| dmen | input | 1 | Enables the nonvolatile region |
| page_q | output | 8 | Current page register value |
| sel_aux | output | 1 | Access goes to the auxiliary RAM |
| sel_nv | output | 1 | Access goes to the nonvolatile region |
| sel_ext | output | 1 | Access goes to the external bus |
| eff_addr | output | 16 | Effective 16-bit address |
| addr_hi_en | output | 1 | Upper address byte may be driven externally |
| min_wait | output | 3 | Minimum wait cycles for this access |
| rd_data | output | 8 | Auxiliary RAM read data, registered |

## Verification
The assertions assume that the control bits and the access fields hold steady between clock edges. They also assume that page_we never lands in the same cycle as an 8-bit access that depends on the old page, because the route is computed from the registered page_q. The stimulus changes inputs only at the falling edge and loads the page in a cycle of its own, with acc_valid low. Random traffic is weighted toward the region boundaries 0FFFH/1000H and 2FFFH/3000H, and toward page values on either side of 10H, so that each routing branch is exercised under every combination of the control bits.

// File: rtl/movx_router_pkg.sv
package movx_router_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int WAIT_W     = 3;
    localparam int AUX_BYTES  = 4096;
    localparam int AUX_AW     = $clog2(AUX_BYTES);
    localparam int PAGE_LIMIT = AUX_BYTES / 256;

    localparam logic [ADDR_W-1:0] NV_LO = 16'h1000;
    localparam logic [ADDR_W-1:0] NV_HI = 16'h2FFF;

    localparam logic [WAIT_W-1:0] WAIT_AUX = 3'd2;
    localparam logic [WAIT_W-1:0] WAIT_NV  = 3'd4;
    localparam logic [WAIT_W-1:0] WAIT_EXT = 3'd1;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_AUX  = 2'd1,
        TGT_NV   = 2'd2,
        TGT_EXT  = 2'd3
    } target_e;

    typedef struct packed {
        target_e             tgt;
        logic [ADDR_W-1:0]   addr;
        logic                hi_en;
        logic [WAIT_W-1:0]   wait_cyc;
    } route_t;

    function automatic logic [WAIT_W-1:0] wait_for(target_e t);
        case (t)
            TGT_AUX: return WAIT_AUX;
            TGT_NV:  return WAIT_NV;
            TGT_EXT: return WAIT_EXT;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/movx_page_reg.sv
module movx_page_reg
    import movx_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] page
);

    always_ff @(posedge clk) begin
        if (rst)
            page <= '0;
        else if (we)
            page <= wdata;
    end

    AST_PAGE_RESET: assert property (@(posedge clk) rst |=> page == '0); // R9
    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (rst)
        we |=> page == $past(wdata)); // R9
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(page)); // R9

endmodule

// File: rtl/movx_decode.sv
module movx_decode
    import movx_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              short_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] page,
    input  logic              exram,
    input  logic              iap,
    input  logic              dmen,
    output route_t            route
);

    logic [ADDR_W-1:0] short_addr;
    logic              page_internal;
    logic              in_aux_range;
    logic              in_nv_range;

    always_comb begin
        page_internal = page < DATA_W'(PAGE_LIMIT);
        short_addr    = {page, addr[7:0]};
        in_aux_range  = addr < ADDR_W'(AUX_BYTES);
        in_nv_range   = (addr >= NV_LO) && (addr <= NV_HI);

        route       = '0;
        route.tgt   = TGT_NONE;
        if (valid) begin
            if (exram) begin
                route.tgt   = TGT_EXT;
                route.addr  = short_mode ? {8'h00, addr[7:0]} : addr;
                route.hi_en = !short_mode;
            end else if (short_mode) begin
                if (page_internal) begin
                    route.tgt  = TGT_AUX;
                    route.addr = short_addr;
                end else begin
                    route.tgt  = TGT_EXT;
                    route.addr = {8'h00, addr[7:0]};
                end
                route.hi_en = 1'b0;
            end else begin
                route.addr  = addr;
                route.hi_en = 1'b1;
                if (!iap && in_aux_range)
                    route.tgt = TGT_AUX;
                else if (!iap && dmen && in_nv_range)
                    route.tgt = TGT_NV;
                else
                    route.tgt = TGT_EXT;
            end
            route.wait_cyc = wait_for(route.tgt);
        end
    end

    AST_VALID_HAS_TARGET: assert property (@(posedge clk) disable iff (rst)
        valid |-> route.tgt != TGT_NONE); // R8
    AST_IDLE_NO_TARGET: assert property (@(posedge clk) disable iff (rst)
        !valid |-> route.tgt == TGT_NONE && route.wait_cyc == '0); // R8
    AST_EXRAM_EXTERNAL: assert property (@(posedge clk) disable iff (rst)
        valid && exram |-> route.tgt == TGT_EXT); // R6
    AST_SHORT_NEVER_NV: assert property (@(posedge clk) disable iff (rst)
        valid && short_mode |-> route.tgt != TGT_NV); // R5
    AST_PAGE_NOT_ON_PINS: assert property (@(posedge clk) disable iff (rst)
        valid && short_mode |-> !route.hi_en && (route.tgt != TGT_EXT || route.addr[15:8] == 8'h00)); // R3
    AST_IAP_BYPASS: assert property (@(posedge clk) disable iff (rst)
        valid && !short_mode && iap |-> route.tgt == TGT_EXT); // R4
    AST_AUX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        route.tgt == TGT_AUX |-> route.addr < ADDR_W'(AUX_BYTES)); // R1

endmodule

// File: rtl/movx_aux_ram.sv
module movx_aux_ram
    import movx_router_pkg::*;
#(
    parameter int DEPTH = AUX_BYTES,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we)
                mem[addr] <= wdata;
            else
                rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/movx_router.sv
module movx_router
    import movx_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_short,
    input  logic        acc_write,
    input  logic [15:0] acc_addr,
    input  logic [7:0]  acc_wdata,
    input  logic        page_we,
    input  logic [7:0]  page_wdata,
    input  logic        exram,
    input  logic        iap,
    input  logic        dmen,
    output logic [7:0]  page_q,
    output logic        sel_aux,
    output logic        sel_nv,
    output logic        sel_ext,
    output logic [15:0] eff_addr,
    output logic        addr_hi_en,
    output logic [2:0]  min_wait,
    output logic [7:0]  rd_data
);

    route_t route;

    movx_page_reg u_page (
        .clk   (clk),
        .rst   (rst),
        .we    (page_we),
        .wdata (page_wdata),
        .page  (page_q)
    );

    movx_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .valid      (acc_valid),
        .short_mode (acc_short),
        .addr       (acc_addr),
        .page       (page_q),
        .exram      (exram),
        .iap        (iap),
        .dmen       (dmen),
        .route      (route)
    );

    always_comb begin
        sel_aux    = route.tgt == TGT_AUX;
        sel_nv     = route.tgt == TGT_NV;
        sel_ext    = route.tgt == TGT_EXT;
        eff_addr   = route.addr;
        addr_hi_en = route.hi_en;
        min_wait   = route.wait_cyc;
    end

    movx_aux_ram #(.DEPTH(AUX_BYTES)) u_ram (
        .clk   (clk),
        .en    (sel_aux),
        .we    (acc_write),
        .addr  (eff_addr[AUX_AW-1:0]),
        .wdata (acc_wdata),
        .rdata (rd_data)
    );

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> $countones({sel_aux, sel_nv, sel_ext}) == 1); // R8
    AST_NO_SELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !(sel_aux || sel_nv || sel_ext)); // R8
    AST_AUX_WAIT: assert property (@(posedge clk) disable iff (rst)
        sel_aux |-> min_wait == 3'd2); // R1
    AST_NV_WAIT: assert property (@(posedge clk) disable iff (rst)
        sel_nv |-> min_wait == 3'd4); // R5
    AST_EXT_WAIT: assert property (@(posedge clk) disable iff (rst)
        sel_ext |-> min_wait == 3'd1); // R7
    AST_NV_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        sel_nv |-> dmen && !iap && !exram); // R5

endmodule

// File: tb/movx_router_tb_top.sv
module movx_router_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_short, acc_write;
    logic [15:0] acc_addr;
    logic [7:0]  acc_wdata;
    logic        page_we;
    logic [7:0]  page_wdata;
    logic        exram, iap, dmen;
    logic [7:0]  page_q;
    logic        sel_aux, sel_nv, sel_ext;
    logic [15:0] eff_addr;
    logic        addr_hi_en;
    logic [2:0]  min_wait;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] model [4096];
    bit         known [4096];
    logic [7:0] page_model;

    always #2 clk = ~clk;

    movx_router dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_short(acc_short),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .page_we(page_we), .page_wdata(page_wdata), .exram(exram), .iap(iap),
        .dmen(dmen), .page_q(page_q), .sel_aux(sel_aux), .sel_nv(sel_nv),
        .sel_ext(sel_ext), .eff_addr(eff_addr), .addr_hi_en(addr_hi_en),
        .min_wait(min_wait), .rd_data(rd_data)
    );

    // expected: {sel_aux, sel_nv, sel_ext, hi_en, wait[2:0], addr[15:0]}
    function automatic logic [22:0] expect_route(bit v, bit s, logic [15:0] a,
                                                 logic [7:0] pg, bit ex, bit ip, bit dm);
        logic [2:0]  tsel;
        logic        hi;
        logic [15:0] ea;
        logic [2:0]  w;
        if (!v) return '0;
        if (ex) begin
            tsel = 3'b001; hi = !s; ea = s ? {8'h00, a[7:0]} : a;
        end else if (s) begin
            hi = 1'b0;
            if (pg < 8'h10) begin tsel = 3'b100; ea = {pg, a[7:0]}; end
            else begin tsel = 3'b001; ea = {8'h00, a[7:0]}; end
        end else begin
            hi = 1'b1; ea = a;
            if (!ip && a < 16'h1000) tsel = 3'b100;
            else if (!ip && dm && a >= 16'h1000 && a <= 16'h2FFF) tsel = 3'b010;
            else tsel = 3'b001;
        end
        w = tsel[2] ? 3'd2 : tsel[1] ? 3'd4 : 3'd1;
        return {tsel, hi, w, ea};
    endfunction

    function automatic string req_of(bit s, logic [15:0] a, logic [7:0] pg, bit ex, bit ip);
        if (ex) return "R6";
        if (s) return (pg < 8'h10) ? "R2" : "R3";
        if (ip) return "R4";
        if (a < 16'h1000) return "R1";
        if (a <= 16'h2FFF) return "R5";
        return "R7";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 0; acc_short = 0; acc_write = 0; acc_addr = '0;
        acc_wdata = '0; page_we = 0; page_wdata = '0;
    endtask

    task automatic set_page(logic [7:0] p);
        @(negedge clk);
        idle();
        page_we = 1; page_wdata = p;
        @(negedge clk);
        page_we = 0;
        page_model = p;
        #1 check("R9", {24'h0, page_q}, {24'h0, p});
    endtask

    // one access; checks routing, then RAM effects
    task automatic access(bit s, bit wr, logic [15:0] a, logic [7:0] d,
                          bit ex, bit ip, bit dm, string req_in);
        logic [22:0] e;
        string req;
        int idx;
        @(negedge clk);
        acc_valid = 1; acc_short = s; acc_write = wr; acc_addr = a; acc_wdata = d;
        exram = ex; iap = ip; dmen = dm;
        #1;
        req = (req_in.len() > 0) ? req_in : req_of(s, a, page_model, ex, ip);
        e = expect_route(1, s, a, page_model, ex, ip, dm);
        check(req, {9'h0, sel_aux, sel_nv, sel_ext, addr_hi_en, min_wait, eff_addr},
              {9'h0, e});
        check("R8", {29'h0, sel_aux, sel_nv, sel_ext},
              {29'h0, 3'b100 >> (sel_aux ? 0 : sel_nv ? 1 : 2)} & 32'h7);
        @(posedge clk);
        idx = int'(e[11:0]);
        if (e[22]) begin
            if (wr) begin
                model[idx] = d; known[idx] = 1;
            end else if (known[idx]) begin
                #1 check("R10", {24'h0, rd_data}, {24'h0, model[idx]});
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) known[i] = 0;
        idle(); exram = 0; iap = 0; dmen = 0;
        page_model = 8'h00;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        check("R9", {24'h0, page_q}, 32'h0);
        check("R8", {29'h0, sel_aux, sel_nv, sel_ext, min_wait} , 32'h0);

        // directed corners
        access(0, 1, 16'h0FFF, 8'hA5, 0, 0, 0, "R1");
        access(0, 0, 16'h0FFF, 8'h00, 0, 0, 0, "R10");
        access(0, 0, 16'h1000, 8'h00, 0, 0, 1, "R5");
        access(0, 0, 16'h2FFF, 8'h00, 0, 0, 1, "R5");
        access(0, 0, 16'h2FFF, 8'h00, 0, 0, 0, "R5");
        access(0, 0, 16'h3000, 8'h00, 0, 0, 1, "R7");
        access(0, 0, 16'h0123, 8'h00, 0, 1, 1, "R4");
        access(0, 0, 16'h1800, 8'h00, 0, 1, 1, "R4");
        access(0, 0, 16'h0123, 8'h00, 1, 0, 1, "R6");
        set_page(8'h0F);
        access(1, 1, 16'hAB42, 8'h3C, 0, 0, 1, "R2");
        access(0, 0, 16'h0F42, 8'h00, 0, 0, 0, "R10");
        access(1, 0, 16'h0042, 8'h00, 0, 0, 0, "R10");
        access(1, 0, 16'h0042, 8'h00, 1, 0, 0, "R6");
        set_page(8'h10);
        access(1, 0, 16'h0077, 8'h00, 0, 0, 1, "R3");
        set_page(8'hFF);
        access(1, 1, 16'h1299, 8'h11, 0, 0, 1, "R3");
        check("R10", {24'h0, rd_data}, {24'h0, model[12'hF42]});

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            int k;
            if (n % 50 == 0) begin
                k = $urandom_range(0, 3);
                set_page(k == 0 ? 8'h10 : k == 1 ? 8'h0F : 8'($urandom()));
            end
            k = $urandom_range(0, 5);
            case (k)
                0: a = 16'h0FFF + 16'($urandom_range(0, 2));
                1: a = 16'h2FFF + 16'($urandom_range(0, 2));
                2: a = 16'($urandom_range(0, 16'h0FFF));
                3: a = 16'($urandom_range(16'h1000, 16'h2FFF));
                default: a = 16'($urandom());
            endcase
            access($urandom_range(0, 1), $urandom_range(0, 1), a, 8'($urandom()),
                   $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                   $urandom_range(0, 1), "");
            if (n % 97 == 0) begin
                @(negedge clk); idle();
                #1 check("R8", {26'h0, sel_aux, sel_nv, sel_ext, min_wait}, 32'h0);
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule